// File: doc/BRIEF.md
# Watchdog Register Write Guard

This unit sits between a register bus and the control registers of a watchdog timer and decides, write by write, whether each access may reach its target. A protection register takes one-byte keys that move the unit between three states. In the unprotected state, ordinary configuration is allowed. In the releasable state, a single unlock key returns the unit to the unprotected state. In the permanent state, only a reset brings the unit back. While either protected state is active, the only write that passes is the service (counter clear) code to the control register. Configuration writes, enable writes and the disable code are dropped.

The unit also holds a lock bit. The lock bit drives an output that blocks writes to an oscillator control bit located elsewhere on the chip. Writes that are let through appear one cycle later as a single-cycle strobe per target register, together with the registered write data. The watchdog supplies two status inputs: its enable bit and its running flag. The unit answers reads of the two registers it owns. Reset is synchronous and active high.

Top module: `wdt_write_guard`

## Requirements
- R1: After reset the protection state is unprotected (prot_mode 2'b00), a read of offset 0x00 returns 0x1E, osc_lock is 0 and no forward strobe is high.
- R2: With wdt_en high, writing 0xA9 to offset 0x00 from the unprotected state enters the permanent state (prot_mode 2'b10). In the permanent state every write to offset 0x00 is ignored, so only reset leaves it.
- R3: With wdt_en high, writing 0x74 to offset 0x00 from the unprotected state enters the releasable state (prot_mode 2'b01). From the releasable state, only 0x1E is accepted, and it returns the unit to the unprotected state. Every other value leaves the state unchanged.
- R4: A write to offset 0x00 changes nothing while wdt_en is low. A value other than 0xA9, 0x74 or 0x1E never changes the state.
- R5: A write to the control offset 0x08 is forwarded (fwd_ctl_we) when its low byte is 0x4E in any state, or when its low byte is 0xB1 in the unprotected state. Every other write to 0x08 is dropped.
- R6: A write to the mode offset 0x0C is forwarded (fwd_mod_we) only when the unit is unprotected and wdt_run is low.
- R7: A write to offset 0x14 loads bit 0 of the data into the lock bit only when the unit is unprotected and wdt_run is low. Output osc_lock equals the lock bit.
- R8: A write to the enable offset 0x04 is forwarded (fwd_en_we) only in the unprotected state.
- R9: Reads are registered with one cycle of latency. Offset 0x00 returns the current key (0x1E, 0x74 or 0xA9), offset 0x14 returns the lock bit in bit 0, and all other offsets and all upper bits return 0.
- R10: Writes to the monitor offset 0x10 or to an unmapped offset are never forwarded. At most one strobe is high in any cycle. On a strobe, fwd_data equals the accepted write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write request |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | DATA_W | Registered read data |
| wdt_en | input | 1 | Watchdog enable bit from the timer |
| wdt_run | input | 1 | Watchdog running flag from the timer |
| prot_mode | output | 2 | Protection state: 00 none, 01 releasable, 10 permanent |
| osc_lock | output | 1 | Inhibits writes to the external oscillator control bit |
| fwd_en_we | output | 1 | Forward strobe for the enable register |
| fwd_ctl_we | output | 1 | Forward strobe for the control register |
| fwd_mod_we | output | 1 | Forward strobe for the mode register |
| fwd_data | output | DATA_W | Data accompanying a forward strobe |

## Verification
The hardest situation to reach is the permanent state combined with a particular status pairing and a particular write, because nothing except reset leaves that state. Every trial in the sweep therefore starts from a reset and replays the key that sets up its start state. It then makes one write under a chosen pairing of wdt_en and wdt_run. The sweep covers every start state, every status pairing, every mapped offset plus one unmapped offset, and all 256 low-byte values. Expected strobes, next state, key readback and lock value are worked out in the bench from the rules above.

// File: rtl/wp_pkg.sv
package wp_pkg;
  typedef enum logic [1:0] {
    PM_NONE = 2'b00,
    PM_REL  = 2'b01,
    PM_PERM = 2'b10
  } pmode_t;

  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] KEY_OPEN = 8'h1E;
  localparam logic [KEY_W-1:0] KEY_PERM = 8'hA9;
  localparam logic [KEY_W-1:0] KEY_REL  = 8'h74;
  localparam logic [KEY_W-1:0] CODE_SVC = 8'h4E;
  localparam logic [KEY_W-1:0] CODE_OFF = 8'hB1;

  localparam int NREG = 6;
  localparam int IX_PROT = 0;
  localparam int IX_EN   = 1;
  localparam int IX_CTL  = 2;
  localparam int IX_MOD  = 3;
  localparam int IX_MON  = 4;
  localparam int IX_OSC  = 5;
  localparam int OFF_STEP = 4;

  function automatic logic [KEY_W-1:0] key_of(pmode_t m);
    case (m)
      PM_REL:  key_of = KEY_REL;
      PM_PERM: key_of = KEY_PERM;
      default: key_of = KEY_OPEN;
    endcase
  endfunction
endpackage

// File: rtl/wp_decode.sv
module wp_decode
  import wp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NREG-1:0]   hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    localparam logic [ADDR_W-1:0] OFF = ADDR_W'(i * OFF_STEP);
    assign hit[i] = wr_en && (wr_addr == OFF);
  end
endmodule

// File: rtl/wp_keyfsm.sv
module wp_keyfsm
  import wp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key,
  input  logic             wdt_en,
  output pmode_t           mode
);
  pmode_t mode_nx;

  always_comb begin
    mode_nx = mode;
    if (key_we && wdt_en) begin
      unique case (mode)
        PM_NONE: begin
          if (key == KEY_PERM)     mode_nx = PM_PERM;
          else if (key == KEY_REL) mode_nx = PM_REL;
        end
        PM_REL: begin
          if (key == KEY_OPEN) mode_nx = PM_NONE;
        end
        default: mode_nx = mode;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode <= PM_NONE;
    else     mode <= mode_nx;
  end
endmodule

// File: rtl/wp_gate.sv
module wp_gate
  import wp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NREG-1:0]   hit,
  input  logic [DATA_W-1:0] wr_data,
  input  pmode_t            mode,
  input  logic              wdt_run,
  output logic              en_we,
  output logic              ctl_we,
  output logic              mod_we,
  output logic [DATA_W-1:0] fdata,
  output logic              lock
);
  logic open_st, cfg_ok, svc, off, pass_en, pass_ctl, pass_mod, pass_osc;

  assign open_st  = (mode == PM_NONE);
  assign cfg_ok   = open_st && !wdt_run;
  assign svc      = (wr_data[KEY_W-1:0] == CODE_SVC);
  assign off      = (wr_data[KEY_W-1:0] == CODE_OFF);
  assign pass_en  = hit[IX_EN] && open_st;
  assign pass_ctl = hit[IX_CTL] && (svc || (off && open_st));
  assign pass_mod = hit[IX_MOD] && cfg_ok;
  assign pass_osc = hit[IX_OSC] && cfg_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_we  <= 1'b0;
      ctl_we <= 1'b0;
      mod_we <= 1'b0;
      fdata  <= '0;
      lock   <= 1'b0;
    end else begin
      en_we  <= pass_en;
      ctl_we <= pass_ctl;
      mod_we <= pass_mod;
      if (pass_en || pass_ctl || pass_mod) fdata <= wr_data;
      if (pass_osc) lock <= wr_data[0];
    end
  end
endmodule

// File: rtl/wdt_write_guard.sv
module wdt_write_guard
  import wp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wdt_en,
  input  logic              wdt_run,
  output logic [1:0]        prot_mode,
  output logic              osc_lock,
  output logic              fwd_en_we,
  output logic              fwd_ctl_we,
  output logic              fwd_mod_we,
  output logic [DATA_W-1:0] fwd_data
);
  localparam logic [ADDR_W-1:0] RD_PROT = ADDR_W'(IX_PROT * OFF_STEP);
  localparam logic [ADDR_W-1:0] RD_OSC  = ADDR_W'(IX_OSC * OFF_STEP);

  logic [NREG-1:0] hit;
  pmode_t          mode;
  logic            lock;

  wp_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .hit    (hit)
  );

  wp_keyfsm u_fsm (
    .clk   (clk),
    .rst   (rst),
    .key_we(hit[IX_PROT]),
    .key   (wr_data[KEY_W-1:0]),
    .wdt_en(wdt_en),
    .mode  (mode)
  );

  wp_gate #(.DATA_W(DATA_W)) u_gate (
    .clk    (clk),
    .rst    (rst),
    .hit    (hit),
    .wr_data(wr_data),
    .mode   (mode),
    .wdt_run(wdt_run),
    .en_we  (fwd_en_we),
    .ctl_we (fwd_ctl_we),
    .mod_we (fwd_mod_we),
    .fdata  (fwd_data),
    .lock   (lock)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      if (rd_addr == RD_PROT)     rd_data <= DATA_W'(key_of(mode));
      else if (rd_addr == RD_OSC) rd_data <= DATA_W'(lock);
      else                        rd_data <= '0;
    end
  end

  assign prot_mode = mode;
  assign osc_lock  = lock;
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wdt_en,
  input logic              wdt_run,
  input logic [1:0]        prot_mode,
  input logic              osc_lock,
  input logic              fwd_en_we,
  input logic              fwd_ctl_we,
  input logic              fwd_mod_we,
  input logic [DATA_W-1:0] fwd_data
);
  assert_perm_sticks_R2: assert property (@(posedge clk) disable iff (rst)
    prot_mode == 2'b10 |=> prot_mode == 2'b10);

  assert_key_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && prot_mode != $past(prot_mode)) |-> $past(wdt_en));

  assert_rel_exit_only_open_R3: assert property (@(posedge clk) disable iff (rst)
    (prot_mode == 2'b01) |=> (prot_mode == 2'b01 || prot_mode == 2'b00));

  assert_ctl_service_only_R5: assert property (@(posedge clk) disable iff (rst)
    (fwd_ctl_we && $past(prot_mode) != 2'b00) |-> fwd_data[7:0] == 8'h4E);

  assert_mode_blocked_R6: assert property (@(posedge clk) disable iff (rst)
    fwd_mod_we |-> ($past(prot_mode) == 2'b00 && !$past(wdt_run)));

  assert_lock_guarded_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(osc_lock)) |-> ($past(prot_mode) == 2'b00 && !$past(wdt_run)));

  assert_enable_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    fwd_en_we |-> $past(prot_mode) == 2'b00);

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fwd_en_we, fwd_ctl_we, fwd_mod_we}));
endmodule

bind wdt_write_guard wp_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wdt_en    (wdt_en),
  .wdt_run   (wdt_run),
  .prot_mode (prot_mode),
  .osc_lock  (osc_lock),
  .fwd_en_we (fwd_en_we),
  .fwd_ctl_we(fwd_ctl_we),
  .fwd_mod_we(fwd_mod_we),
  .fwd_data  (fwd_data)
);

// File: tb/wdt_write_guard_bench.sv
module wdt_write_guard_bench;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          wdt_en = 1'b1;
  logic          wdt_run = 1'b0;
  logic [1:0]    prot_mode;
  logic          osc_lock, fwd_en_we, fwd_ctl_we, fwd_mod_we;
  logic [DW-1:0] fwd_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  wdt_write_guard #(.ADDR_W(AW), .DATA_W(DW)) u_wdt_write_guard (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wdt_en(wdt_en), .wdt_run(wdt_run),
    .prot_mode(prot_mode), .osc_lock(osc_lock), .fwd_en_we(fwd_en_we),
    .fwd_ctl_we(fwd_ctl_we), .fwd_mod_we(fwd_mod_we), .fwd_data(fwd_data)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] key_for(int st);
    return (st == 1) ? 8'h74 : (st == 2) ? 8'hA9 : 8'h1E;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; wdt_en = 1'b1; wdt_run = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_all();
    // R1: reset state
    do_reset();
    rd_addr = 8'h00;
    @(negedge clk);
    chk(prot_mode == 2'b00, "R1 mode", prot_mode, 0);
    chk(rd_data == 32'h1E, "R1 key read", rd_data, 32'h1E);
    chk(osc_lock == 1'b0, "R1 lock", osc_lock, 0);
    chk({fwd_en_we, fwd_ctl_we, fwd_mod_we} == 3'b000, "R1 strobes",
        {fwd_en_we, fwd_ctl_we, fwd_mod_we}, 0);

    // R7 and R9: lock set, read back, clear; monitor read is zero
    bus_wr(8'h14, 8'h01);
    chk(osc_lock == 1'b1, "R7 lock set", osc_lock, 1);
    rd_addr = 8'h14;
    @(negedge clk);
    chk(rd_data == 32'h1, "R9 lock read", rd_data, 1);
    rd_addr = 8'h10;
    @(negedge clk);
    chk(rd_data == 32'h0, "R9 monitor read", rd_data, 0);
    bus_wr(8'h14, 8'h00);
    chk(osc_lock == 1'b0, "R7 lock clear", osc_lock, 0);

    // sweep over start state, status inputs, offset and data byte
    for (int st = 0; st < 3; st++)
      for (int e = 0; e < 2; e++)
        for (int r = 0; r < 2; r++)
          for (int ai = 0; ai < 7; ai++)
            for (int d = 0; d < 256; d++) begin
              logic [AW-1:0] a;
              int nst;
              logic x_en, x_ctl, x_mod, x_lock;
              a = AW'(ai * 4);
              do_reset();
              if (st != 0) bus_wr(8'h00, key_for(st));
              nst = st;
              if (a == 8'h00 && e == 1) begin
                if (st == 0 && d == 8'hA9) nst = 2;
                else if (st == 0 && d == 8'h74) nst = 1;
                else if (st == 1 && d == 8'h1E) nst = 0;
              end
              x_en   = (a == 8'h04) && st == 0;
              x_ctl  = (a == 8'h08) && (d == 8'h4E || (st == 0 && d == 8'hB1));
              x_mod  = (a == 8'h0C) && st == 0 && r == 0;
              x_lock = (a == 8'h14) && st == 0 && r == 0 && d[0];
              wdt_en = e[0]; wdt_run = r[0]; rd_addr = 8'h00;
              bus_wr(a, 8'(d));
              chk(fwd_en_we == x_en, "R8 enable strobe", fwd_en_we, x_en);
              chk(fwd_ctl_we == x_ctl, "R5 control strobe", fwd_ctl_we, x_ctl);
              chk(fwd_mod_we == x_mod, "R6 mode strobe", fwd_mod_we, x_mod);
              chk(osc_lock == x_lock, "R7 lock", osc_lock, x_lock);
              chk(prot_mode == 2'(nst), (st == 2) ? "R2 state" : (st == 1) ? "R3 state" : "R4 state",
                  prot_mode, nst);
              if (x_en || x_ctl || x_mod)
                chk(fwd_data == DW'(d), "R10 data", fwd_data, d);
              if (a == 8'h10 || a == 8'h18)
                chk({fwd_en_we, fwd_ctl_we, fwd_mod_we} == 3'b000, "R10 no forward",
                    {fwd_en_we, fwd_ctl_we, fwd_mod_we}, 0);
              @(negedge clk);
              chk(rd_data == DW'(key_for(nst)), "R9 key read", rd_data, key_for(nst));
              chk({fwd_en_we, fwd_ctl_we, fwd_mod_we} == 3'b000, "R10 single pulse",
                  {fwd_en_we, fwd_ctl_we, fwd_mod_we}, 0);
            end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (195000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule